// File: doc/BRIEF.md
# Chip-Select Range Decoder

This block takes a physical address and decides which of a small set of memory chip selects owns it. Each chip select has one programmable bounds word. The word holds a first unit and a last unit, both counted in 16 MiB steps, and the region runs through the final byte of the last unit. Software loads the bounds through a simple write port. The decoder then compares the upper address bits of each presented address against every populated window at the same time.

The result appears one clock after the address is presented. It is given in three forms: a one-hot chip-select vector, a binary index and a miss flag for addresses that no populated window covers. A chip select whose first and last units are equal is treated as absent and never claims an address. When windows overlap, the chip select with the lowest number wins.

Top module: `csb_decoder`

## Requirements
- R1: After reset, every bounds word is zero, so all chip selects are unpopulated, and `res_vld`, `cs_hot`, `cs_idx` and `miss` are all zero.
- R2: A cycle with `wr_en` high loads `wr_data` into the bounds word of chip select `wr_sel`. The first unit is taken from `wr_data[31:16]` and the last unit from `wr_data[15:0]`. The other bounds words are left unchanged.
- R3: A populated chip select claims an address when `addr[39:24]` is at least its first unit and at most its last unit. The last unit is inclusive, so byte offsets 0 and 0xFFFFFF within it both match.
- R4: A chip select whose first unit equals its last unit never claims any address.
- R5: If no populated chip select claims the address, the result has `miss`=1, `cs_hot`=0 and `cs_idx`=0. Otherwise `miss`=0.
- R6: When several chip selects claim an address, only the lowest-numbered one is reported.
- R7: An address sampled with `addr_vld` high produces its result, with `res_vld`=1, on the next clock edge. A cycle with `addr_vld` low clears `res_vld` and leaves `cs_hot`, `cs_idx` and `miss` unchanged.
- R8: A lookup presented in the same cycle as a write uses the old bounds. A lookup presented in the following cycle uses the new bounds.
- R9: `cs_hot` has at most one bit set. On a hit, bit `cs_idx` is the bit that is set.
- R10: A chip select whose first unit is greater than its last unit claims no address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bounds write strobe |
| wr_sel | input | 2 | Chip select whose bounds are written |
| wr_data | input | 32 | Bounds word: first unit in [31:16], last unit in [15:0] |
| addr_vld | input | 1 | Address valid |
| addr | input | 40 | Physical byte address |
| res_vld | output | 1 | Result valid, one cycle after `addr_vld` |
| cs_hot | output | 4 | One-hot winning chip select |
| cs_idx | output | 2 | Binary index of the winning chip select |
| miss | output | 1 | No populated chip select covers the address |

## Verification
Each bounds layout is tested by sweeping every address unit from 0 to 47 and the top sixteen units of the space. Every unit is tried at byte offset 0 and at offset 0xFFFFFF. The offset pair separates an inclusive last unit from an exclusive one. A layout with disjoint windows and gaps checks window edges and misses. An overlapping layout exposes a wrong priority order. A layout with equal and reversed bounds separates the unpopulated rule from a plain range compare. Separate sequences cover a write colliding with a lookup in the same cycle, and holding the result while `addr_vld` is low.

// File: rtl/csb_pkg.sv
package csb_pkg;
  localparam int unsigned FIELD_W = 16;
  localparam int unsigned WORD_W  = 2 * FIELD_W;

  typedef logic [FIELD_W-1:0] unit_t;

  typedef struct packed {
    unit_t first_u;
    unit_t last_u;
  } bounds_t;
endpackage

// File: rtl/csb_bounds_regs.sv
module csb_bounds_regs
  import csb_pkg::*;
#(
  parameter int unsigned NUM_CS = 4,
  localparam int unsigned IDX_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_sel,
  input  logic [WORD_W-1:0]     wr_data,
  output bounds_t [NUM_CS-1:0]  bounds
);
  bounds_t [NUM_CS-1:0] bounds_q;
  bounds_t              bounds_d;
  logic    [NUM_CS-1:0] load_en;

  always_comb begin
    bounds_d = bounds_t'(wr_data);
  end

  for (genvar g = 0; g < NUM_CS; g++) begin : g_entry
    assign load_en[g] = wr_en && (wr_sel == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bounds_q[g] <= '0;
      end else if (load_en[g]) begin
        bounds_q[g] <= bounds_d;
      end
    end
  end

  assign bounds = bounds_q;

  AST_ONE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(load_en)) else $error("AST_ONE_LOAD"); // R2
endmodule

// File: rtl/csb_range_cmp.sv
module csb_range_cmp
  import csb_pkg::*;
(
  input  unit_t   unit,
  input  bounds_t bnd,
  output logic    hit
);
  logic populated;
  logic above_first;
  logic below_last;

  always_comb begin
    populated   = (bnd.first_u != bnd.last_u);
    above_first = (unit >= bnd.first_u);
    below_last  = (unit <= bnd.last_u);
    hit         = populated && above_first && below_last;
  end
endmodule

// File: rtl/csb_prio_enc.sv
module csb_prio_enc #(
  parameter int unsigned N = 4,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req,
  output logic [N-1:0]     grant,
  output logic [IDX_W-1:0] idx,
  output logic             any
);
  always_comb begin
    grant = '0;
    idx   = '0;
    any   = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        idx      = IDX_W'(i);
        any      = 1'b1;
      end
    end
  end

  always_comb begin
    AST_GRANT_ONE: assert (!any || $countones(grant) == 1) else $error("AST_GRANT_ONE"); // R9
  end
endmodule

// File: rtl/csb_decoder.sv
module csb_decoder
  import csb_pkg::*;
#(
  parameter int unsigned NUM_CS = 4,
  parameter int unsigned ADDR_W = 40,
  localparam int unsigned IDX_W   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
  localparam int unsigned UNIT_LSB = ADDR_W - FIELD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_sel,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              addr_vld,
  input  logic [ADDR_W-1:0] addr,
  output logic              res_vld,
  output logic [NUM_CS-1:0] cs_hot,
  output logic [IDX_W-1:0]  cs_idx,
  output logic              miss
);
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_int = rst_sync_q[1];

  bounds_t [NUM_CS-1:0] bounds;
  logic    [NUM_CS-1:0] hit_vec;
  logic    [NUM_CS-1:0] grant;
  logic    [IDX_W-1:0]  grant_idx;
  logic                 grant_any;
  unit_t                addr_unit;

  assign addr_unit = addr[ADDR_W-1:UNIT_LSB];

  csb_bounds_regs #(.NUM_CS(NUM_CS)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .bounds  (bounds)
  );

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cmp
    csb_range_cmp u_cmp (
      .unit (addr_unit),
      .bnd  (bounds[g]),
      .hit  (hit_vec[g])
    );
  end

  csb_prio_enc #(.N(NUM_CS)) u_prio (
    .req   (hit_vec),
    .grant (grant),
    .idx   (grant_idx),
    .any   (grant_any)
  );

  logic              vld_q,  vld_d;
  logic [NUM_CS-1:0] hot_q,  hot_d;
  logic [IDX_W-1:0]  idx_q,  idx_d;
  logic              miss_q, miss_d;

  always_comb begin
    vld_d  = addr_vld;
    hot_d  = hot_q;
    idx_d  = idx_q;
    miss_d = miss_q;
    if (addr_vld) begin
      hot_d  = grant;
      idx_d  = grant_idx;
      miss_d = !grant_any;
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      vld_q  <= 1'b0;
      hot_q  <= '0;
      idx_q  <= '0;
      miss_q <= 1'b0;
    end else begin
      vld_q  <= vld_d;
      hot_q  <= hot_d;
      idx_q  <= idx_d;
      miss_q <= miss_d;
    end
  end

  assign res_vld = vld_q;
  assign cs_hot  = hot_q;
  assign cs_idx  = idx_q;
  assign miss    = miss_q;

  AST_HOT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n_int)
    $onehot0(hot_q)) else $error("AST_HOT_SINGLE"); // R9
  AST_IDX_MATCH: assert property (@(posedge clk) disable iff (!rst_n_int)
    (vld_q && !miss_q) |-> hot_q[idx_q]) else $error("AST_IDX_MATCH"); // R9
  AST_MISS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n_int)
    miss_q |-> (hot_q == '0 && idx_q == '0)) else $error("AST_MISS_EMPTY"); // R5
  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n_int)
    addr_vld |=> res_vld) else $error("AST_ONE_CYCLE"); // R7
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n_int)
    !addr_vld |=> (!res_vld && $stable(cs_hot) && $stable(cs_idx) && $stable(miss)))
    else $error("AST_HOLD_IDLE"); // R7
endmodule

// File: tb/csb_decoder_bench.sv
module csb_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_sel;
  logic [31:0] wr_data;
  logic        addr_vld;
  logic [39:0] addr;
  logic        res_vld;
  logic [3:0]  cs_hot;
  logic [1:0]  cs_idx;
  logic        miss;

  int checks = 0;
  int errors = 0;
  logic [15:0] m_first [4];
  logic [15:0] m_last  [4];

  always #4 clk = ~clk;

  csb_decoder u_csb_decoder (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .addr_vld(addr_vld), .addr(addr), .res_vld(res_vld), .cs_hot(cs_hot),
    .cs_idx(cs_idx), .miss(miss)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_cs(logic [15:0] u);
    for (int i = 0; i < 4; i++) begin
      if (m_first[i] != m_last[i] && u >= m_first[i] && u <= m_last[i]) return i;
    end
    return -1;
  endfunction

  task automatic wr(int sel, logic [15:0] f, logic [15:0] l);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'(sel); wr_data = {f, l};
    @(negedge clk);
    wr_en = 1'b0;
    m_first[sel] = f; m_last[sel] = l;
  endtask

  task automatic look(string req, logic [39:0] a);
    int e;
    addr = a; addr_vld = 1'b1;
    e = exp_cs(a[39:24]);
    @(negedge clk);
    chk(req, {31'd0, res_vld}, 32'd1);
    chk(req, {28'd0, cs_hot}, (e < 0) ? 32'd0 : (32'd1 << e));
    chk(req, {30'd0, cs_idx}, (e < 0) ? 32'd0 : 32'(e));
    chk(req, {31'd0, miss}, (e < 0) ? 32'd1 : 32'd0);
  endtask

  task automatic sweep(string req);
    for (int u = 0; u < 48; u++) begin
      look(req, {16'(u), 24'h000000});
      look(req, {16'(u), 24'hFFFFFF});
    end
    for (int u = 16'hFFF0; u <= 16'hFFFF; u++) begin
      look(req, {16'(u), 24'h000000});
      look(req, {16'(u), 24'hFFFFFF});
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0; addr_vld = 1'b0; addr = '0;
    for (int i = 0; i < 4; i++) begin m_first[i] = '0; m_last[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state of outputs
    chk("R1", {31'd0, res_vld}, 32'd0);
    chk("R1", {28'd0, cs_hot}, 32'd0);
    chk("R1", {30'd0, cs_idx}, 32'd0);
    chk("R1", {31'd0, miss}, 32'd0);
    // R1: all bounds zero, so every lookup misses
    look("R1", 40'h00_0000_0000);
    look("R1", 40'h00_05FF_FFFF);
    addr_vld = 1'b0;

    // R2 R3 R4 R5: disjoint windows, two unpopulated
    wr(0, 16'd2, 16'd5);
    wr(1, 16'd6, 16'd6);
    wr(2, 16'd12, 16'd12);
    wr(3, 16'd20, 16'd30);
    sweep("R3");
    // R2: rewrite only cs1, others kept
    wr(1, 16'd6, 16'd9);
    sweep("R2");
    addr_vld = 1'b0;

    // R6: overlapping windows
    wr(0, 16'd10, 16'd15);
    wr(1, 16'd0, 16'd40);
    wr(2, 16'd12, 16'd14);
    wr(3, 16'd3, 16'd3);
    sweep("R6");
    addr_vld = 1'b0;

    // R4 R10: reversed, equal, and top-of-space windows
    wr(0, 16'd9, 16'd4);
    wr(1, 16'd7, 16'd7);
    wr(2, 16'hFFF4, 16'hFFFF);
    wr(3, 16'd1, 16'd2);
    sweep("R10");
    addr_vld = 1'b0;

    // R8: write and lookup in the same cycle
    wr(0, 16'd100, 16'd100);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'd0; wr_data = {16'd100, 16'd101};
    addr = {16'd100, 24'h123456}; addr_vld = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R8", {31'd0, miss}, 32'd1);
    chk("R8", {28'd0, cs_hot}, 32'd0);
    m_first[0] = 16'd100; m_last[0] = 16'd101;
    look("R8", {16'd100, 24'h123456});
    look("R8", {16'd101, 24'hFFFFFF});

    // R7: hold while addr_vld low
    look("R7", {16'd2, 24'h0});
    addr_vld = 1'b0; addr = {16'd101, 24'h0};
    @(negedge clk);
    chk("R7", {31'd0, res_vld}, 32'd0);
    chk("R7", {28'd0, cs_hot}, 32'b1000);
    chk("R7", {30'd0, cs_idx}, 32'd3);
    chk("R7", {31'd0, miss}, 32'd0);
    @(negedge clk);
    chk("R7", {28'd0, cs_hot}, 32'b1000);
    chk("R7", {31'd0, miss}, 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule